// File: doc/BRIEF.md
# Two-Phase Load/Store Reservation Front End

This block sits between the issue side of a load/store path and one data-cache port. Each access goes through two phases. In the first phase the address is handed to an external address checker. The checker answers with success or error, either in the same cycle or any number of cycles later. On success the targeted cache line is held reserved. The requester must then choose to commit (go) or abandon (cancel). No memory access, and in particular no write, reaches the cache port before go. An error ends the access with a one-cycle kill pulse, and the commit phase is skipped.

Stores carry one byte-enable bit per data byte. Loads finish with the read data and a one-cycle valid pulse. While an access is in flight the block reports busy, and new requests are not taken. Data width, address width and cache line size are parameters. The defaults are 64-bit data, 48-bit addresses and 16-byte lines.

Top module: `ldst_resv_front`

## Requirements
- R1: After synchronous reset, busy, chk_valid, resv_valid, mem_en, kill and ld_valid are all low.
- R2: A request is taken at a rising edge where req_ok is high and busy is low. From the next cycle, busy is high and chk_valid is high with chk_addr equal to the taken address.
- R3: If chk_ack is high with chk_err low in a cycle where chk_valid is high (including the first such cycle), resv_valid is high from the next cycle, with resv_line equal to the address shifted right by log2 of the line size (4 by default).
- R4: While chk_valid is high and chk_ack is low, chk_valid stays high in the next cycle and chk_addr does not change.
- R5: If chk_ack and chk_err are both high while chk_valid is high, kill is high for exactly the next cycle. resv_valid and mem_en stay low for that access, and busy is low in the cycle after the kill.
- R6: While resv_valid is high and neither go nor cancel is high, the reservation and resv_line are held, and mem_en stays low.
- R7: go (with cancel low) while resv_valid is high makes mem_en high for exactly the next cycle. In that cycle mem_addr, mem_wdata and mem_wmask carry the request's address, store data and byte enables (bit i enables byte i, bits [8i+7:8i]), and mem_we is 1 for a store and 0 for a load.
- R8: cancel while resv_valid is high returns the block to idle in the next cycle, with no mem_en at all for that access. When go and cancel are high together, cancel wins.
- R9: For a load, ld_valid is high for exactly the cycle after the mem_en cycle. In that cycle ld_data equals mem_rdata, which the cache returns one cycle after mem_en.
- R10: req_ok while busy is high is ignored. It does not change chk_addr, resv_line or the memory access of the current request, and it does not start another access.
- R11: go, cancel and chk_ack while idle are ignored. They produce no mem_en, no kill and no reservation, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_ok | input | 1 | Request address valid flag |
| req_addr | input | ADDR_W | Request byte address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DATA_W | Store data |
| req_wmask | input | MASK_W | Store byte enables |
| busy | output | 1 | Access in flight, new requests not taken |
| chk_valid | output | 1 | Address check request |
| chk_addr | output | ADDR_W | Address under check |
| chk_ack | input | 1 | Check answer present (may be combinational) |
| chk_err | input | 1 | Check answer is an error |
| kill | output | 1 | One-cycle pulse on a failed check |
| resv_valid | output | 1 | A line is reserved, waiting for go or cancel |
| resv_line | output | ADDR_W-LINE_OFF | Reserved line address |
| go | input | 1 | Commit the reserved access |
| cancel | input | 1 | Abandon the reserved access |
| mem_en | output | 1 | Cache port access strobe |
| mem_we | output | 1 | Cache port write enable |
| mem_addr | output | ADDR_W | Cache port address |
| mem_wdata | output | DATA_W | Cache port write data |
| mem_wmask | output | MASK_W | Cache port byte enables |
| mem_rdata | input | DATA_W | Cache read data, one cycle after mem_en |
| ld_valid | output | 1 | Load result pulse |
| ld_data | output | DATA_W | Load result data |

## Verification
The bench drives the check answer both in the same cycle as the check request and after several idle cycles. A design that sampled the answer only once, or let the address drift while waiting, would reserve the wrong line or hang. It also gives a checker error and asserts go and cancel together. In those cases a faulty design would leak a cache access, which the scoreboard flags as an unexpected operation, or would miss the kill pulse. The bench also holds the reservation for several cycles while fresh requests arrive, and it pulses go, cancel and the check answer while idle. These cases catch a design that lets a held or stray handshake start a second access or a spurious write.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CHECK    = 3'd1,
        ST_RESERVED = 3'd2,
        ST_COMMIT   = 3'd3,
        ST_ABORT    = 3'd4
    } lsr_state_e;

    // Decoded phase flags handed from control to the datapath pieces.
    typedef struct packed {
        logic idle;
        logic check;
        logic reserved;
        logic commit;
        logic abort;
    } lsr_phase_t;

    function automatic lsr_state_e lsr_next(
        input lsr_state_e s,
        input logic       start,
        input logic       ack,
        input logic       err,
        input logic       go,
        input logic       cancel
    );
        lsr_state_e n;
        case (s)
            ST_IDLE:     n = start ? ST_CHECK : ST_IDLE;
            ST_CHECK:    n = ack ? (err ? ST_ABORT : ST_RESERVED) : ST_CHECK;
            ST_RESERVED: n = cancel ? ST_IDLE : (go ? ST_COMMIT : ST_RESERVED);
            ST_COMMIT:   n = ST_IDLE;
            ST_ABORT:    n = ST_IDLE;
            default:     n = ST_IDLE;
        endcase
        return n;
    endfunction

    function automatic lsr_phase_t lsr_decode(input lsr_state_e s);
        lsr_phase_t p;
        p.idle     = (s == ST_IDLE);
        p.check    = (s == ST_CHECK);
        p.reserved = (s == ST_RESERVED);
        p.commit   = (s == ST_COMMIT);
        p.abort    = (s == ST_ABORT);
        return p;
    endfunction

endpackage

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
    import lsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_ok,
    input  logic       chk_ack,
    input  logic       chk_err,
    input  logic       go,
    input  logic       cancel,
    output logic       take,
    output lsr_phase_t phase
);

    lsr_state_e state_q;
    lsr_state_e state_d;

    assign take    = (state_q == ST_IDLE) && req_ok;
    assign state_d = lsr_next(state_q, take, chk_ack, chk_err, go, cancel);
    assign phase   = lsr_decode(state_q);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1); // R1
    AST_CHECK_WAITS: assert property (@(posedge clk) disable iff (rst)
        phase.check && !chk_ack |=> phase.check); // R4
    AST_ABORT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        phase.check && chk_ack && chk_err |=> phase.abort); // R5
    AST_ABORT_SHORT: assert property (@(posedge clk) disable iff (rst)
        phase.abort |=> phase.idle); // R5

endmodule

// File: rtl/lsr_req_hold.sv
module lsr_req_hold #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_store,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [MASK_W-1:0] in_wmask,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_store,
    output logic [DATA_W-1:0] q_wdata,
    output logic [MASK_W-1:0] q_wmask
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              store;
        logic [DATA_W-1:0] wdata;
        logic [MASK_W-1:0] wmask;
    } held_req_t;

    held_req_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q.addr  <= in_addr;
            hold_q.store <= in_store;
            hold_q.wdata <= in_wdata;
            hold_q.wmask <= in_wmask;
        end
    end

    assign q_addr  = hold_q.addr;
    assign q_store = hold_q.store;
    assign q_wdata = hold_q.wdata;
    assign q_wmask = hold_q.wmask;

endmodule

// File: rtl/lsr_mem_side.sv
module lsr_mem_side
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lsr_phase_t        phase,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_store,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic [MASK_W-1:0] h_wmask,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [MASK_W-1:0] mem_wmask,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);

    logic ld_pend_q;

    // The port is touched only in the commit phase. Write data and
    // enables are forced to zero on loads so no stray enable can leak.
    assign mem_en    = phase.commit;
    assign mem_we    = phase.commit && h_store;
    assign mem_addr  = h_addr;
    assign mem_wdata = h_store ? h_wdata : '0;
    assign mem_wmask = (phase.commit && h_store) ? h_wmask : '0;

    always_ff @(posedge clk) begin
        if (rst) ld_pend_q <= 1'b0;
        else     ld_pend_q <= phase.commit && !h_store;
    end

    assign ld_valid = ld_pend_q;
    assign ld_data  = mem_rdata;

    AST_WRITE_IN_COMMIT: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en); // R7
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !ld_valid); // R9
    AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_valid) |-> $past(mem_en && !mem_we)); // R9

endmodule

// File: rtl/ldst_resv_front.sv
module ldst_resv_front
    import lsr_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int DATA_W     = 64,
    parameter int MASK_W     = DATA_W / 8,
    parameter int LINE_BYTES = 16,
    parameter int LINE_OFF   = $clog2(LINE_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_ok,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_store,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [MASK_W-1:0]          req_wmask,
    output logic                       busy,
    output logic                       chk_valid,
    output logic [ADDR_W-1:0]          chk_addr,
    input  logic                       chk_ack,
    input  logic                       chk_err,
    output logic                       kill,
    output logic                       resv_valid,
    output logic [ADDR_W-LINE_OFF-1:0] resv_line,
    input  logic                       go,
    input  logic                       cancel,
    output logic                       mem_en,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic [MASK_W-1:0]          mem_wmask,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic                       ld_valid,
    output logic [DATA_W-1:0]          ld_data
);

    localparam int LINE_W = ADDR_W - LINE_OFF;

    lsr_phase_t        phase;
    logic              take;
    logic [ADDR_W-1:0] h_addr;
    logic              h_store;
    logic [DATA_W-1:0] h_wdata;
    logic [MASK_W-1:0] h_wmask;

    lsr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req_ok  (req_ok),
        .chk_ack (chk_ack),
        .chk_err (chk_err),
        .go      (go),
        .cancel  (cancel),
        .take    (take),
        .phase   (phase)
    );

    lsr_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .in_addr  (req_addr),
        .in_store (req_store),
        .in_wdata (req_wdata),
        .in_wmask (req_wmask),
        .q_addr   (h_addr),
        .q_store  (h_store),
        .q_wdata  (h_wdata),
        .q_wmask  (h_wmask)
    );

    lsr_mem_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .h_addr    (h_addr),
        .h_store   (h_store),
        .h_wdata   (h_wdata),
        .h_wmask   (h_wmask),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wmask (mem_wmask),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data)
    );

    assign busy       = !phase.idle;
    assign chk_valid  = phase.check;
    assign chk_addr   = h_addr;
    assign kill       = phase.abort;
    assign resv_valid = phase.reserved;
    assign resv_line  = h_addr[ADDR_W-1:LINE_OFF];

    initial begin
        if (MASK_W * 8 != DATA_W) $error("byte enable width must be DATA_W/8");
        if (LINE_W < 1) $error("line offset exceeds address width");
    end

    AST_CHK_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        chk_valid && !chk_ack |=> chk_valid && $stable(chk_addr)); // R4
    AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        chk_valid && chk_ack && chk_err |=> kill && !mem_en && !resv_valid); // R5
    AST_RESV_HELD: assert property (@(posedge clk) disable iff (rst)
        resv_valid && !go && !cancel |=> resv_valid && $stable(resv_line) && !mem_en); // R6
    AST_COMMIT_AFTER_GO: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_en) |-> $past(resv_valid && go && !cancel)); // R7
    AST_MEM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> !mem_en); // R7
    AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (rst)
        resv_valid && cancel |=> !mem_en && !busy); // R8
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        busy && req_ok && !chk_valid && !resv_valid |=> !chk_valid); // R10

endmodule

// File: tb/test_ldst_resv_front.sv
module test_ldst_resv_front;

    localparam int AW = 48;
    localparam int DW = 64;
    localparam int MW = 8;
    localparam int LO = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_ok = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_store = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [MW-1:0] req_wmask = '0;
    logic          busy, chk_valid, kill, resv_valid;
    logic [AW-1:0] chk_addr;
    logic          chk_ack = 1'b0, chk_err = 1'b0, go = 1'b0, cancel = 1'b0;
    logic [AW-LO-1:0] resv_line;
    logic          mem_en, mem_we, ld_valid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, ld_data;
    logic [MW-1:0] mem_wmask;
    logic [DW-1:0] mem_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic          we;
        logic [DW-1:0] data;
        logic [MW-1:0] mask;
    } mem_op_t;

    mem_op_t       exp_mem[$];
    logic [DW-1:0] exp_ld[$];

    always #5 clk = ~clk;

    ldst_resv_front i_ldst_resv_front (
        .clk(clk), .rst(rst), .req_ok(req_ok), .req_addr(req_addr),
        .req_store(req_store), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .busy(busy), .chk_valid(chk_valid), .chk_addr(chk_addr),
        .chk_ack(chk_ack), .chk_err(chk_err), .kill(kill),
        .resv_valid(resv_valid), .resv_line(resv_line), .go(go), .cancel(cancel),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
        return {a[31:0] ^ 32'hC3A5_0F96, a[31:0]};
    endfunction

    // Cache model: read data one cycle after the access strobe.
    always_ff @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= rd_fn(mem_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every cache access and load result with the scoreboard.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (mem_en) begin
                if (exp_mem.size() == 0) begin
                    check(1'b0, "R8", "unexpected cache access addr", mem_addr, '0);
                end else begin
                    mem_op_t e;
                    e = exp_mem.pop_front();
                    check(mem_addr == e.addr, "R7", "mem_addr", mem_addr, e.addr);
                    check(mem_we == e.we, "R7", "mem_we", mem_we, e.we);
                    if (e.we) begin
                        check(mem_wdata == e.data, "R7", "mem_wdata", mem_wdata, e.data);
                        check(mem_wmask == e.mask, "R7", "mem_wmask", mem_wmask, e.mask);
                    end
                end
            end
            if (ld_valid) begin
                if (exp_ld.size() == 0) begin
                    check(1'b0, "R9", "unexpected load result", ld_data, '0);
                end else begin
                    logic [DW-1:0] d;
                    d = exp_ld.pop_front();
                    check(ld_data == d, "R9", "ld_data", ld_data, d);
                end
            end
        end
    end

    // act: 0 = go, 1 = cancel, 2 = go and cancel together
    task automatic access(input logic [AW-1:0] a, input bit st,
                          input logic [DW-1:0] wd, input logic [MW-1:0] wm,
                          input int delay, input bit err, input int act,
                          input int hold);
        check(busy == 1'b0, "R2", "busy before request", busy, 0);
        req_ok = 1'b1; req_addr = a; req_store = st; req_wdata = wd; req_wmask = wm;
        @(negedge clk);
        // R10: a new request while busy must not be taken
        req_addr = a ^ 48'h0000_0F0F_0000; req_store = ~st;
        check(chk_valid == 1'b1, "R2", "chk_valid after take", chk_valid, 1);
        check(chk_addr == a, "R2", "chk_addr after take", chk_addr, a);
        check(busy == 1'b1, "R2", "busy after take", busy, 1);
        for (int d = 0; d < delay; d++) begin
            @(negedge clk);
            check(chk_valid == 1'b1, "R4", "chk_valid while waiting", chk_valid, 1);
            check(chk_addr == a, "R10", "chk_addr stable under new request", chk_addr, a);
        end
        chk_ack = 1'b1; chk_err = err;
        @(negedge clk);
        chk_ack = 1'b0; chk_err = 1'b0;
        if (err) begin
            req_ok = 1'b0;
            check(kill == 1'b1, "R5", "kill after error", kill, 1);
            check(resv_valid == 1'b0, "R5", "no reservation after error", resv_valid, 0);
            @(negedge clk);
            check(kill == 1'b0, "R5", "kill is one cycle", kill, 0);
            check(busy == 1'b0, "R5", "idle after kill", busy, 0);
            return;
        end
        check(resv_valid == 1'b1, "R3", "resv_valid after ok", resv_valid, 1);
        check(resv_line == a[AW-1:LO], "R3", "resv_line", resv_line, a[AW-1:LO]);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(resv_valid == 1'b1, "R6", "reservation held", resv_valid, 1);
            check(resv_line == a[AW-1:LO], "R10", "resv_line stable", resv_line, a[AW-1:LO]);
            check(mem_en == 1'b0, "R6", "no access while reserved", mem_en, 0);
        end
        req_ok = 1'b0;
        go = (act != 1); cancel = (act != 0);
        if (act == 0) begin
            mem_op_t e;
            e.addr = a; e.we = st; e.data = wd; e.mask = wm;
            exp_mem.push_back(e);
            if (!st) exp_ld.push_back(rd_fn(a));
        end
        @(negedge clk);
        go = 1'b0; cancel = 1'b0;
        if (act != 0) begin
            check(busy == 1'b0, "R8", "idle after cancel", busy, 0);
            check(mem_en == 1'b0, "R8", "no access after cancel", mem_en, 0);
        end else begin
            check(mem_en == 1'b1, "R7", "mem_en after go", mem_en, 1);
            @(negedge clk);
            check(mem_en == 1'b0, "R7", "mem_en one cycle", mem_en, 0);
            check(ld_valid == !st, "R9", "ld_valid after read", ld_valid, !st);
            check(busy == 1'b0, "R10", "no second access started", busy, 0);
            @(negedge clk);
            check(ld_valid == 1'b0, "R9", "ld_valid one cycle", ld_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(busy == 0, "R1", "busy", busy, 0);
        check(chk_valid == 0, "R1", "chk_valid", chk_valid, 0);
        check(resv_valid == 0, "R1", "resv_valid", resv_valid, 0);
        check(mem_en == 0, "R1", "mem_en", mem_en, 0);
        check(kill == 0, "R1", "kill", kill, 0);
        check(ld_valid == 0, "R1", "ld_valid", ld_valid, 0);

        // R11 stray handshakes while idle
        go = 1; cancel = 1; chk_ack = 1; chk_err = 1;
        repeat (2) @(negedge clk);
        check(busy == 0, "R11", "busy after stray handshakes", busy, 0);
        check(kill == 0, "R11", "kill after stray handshakes", kill, 0);
        check(resv_valid == 0, "R11", "resv after stray handshakes", resv_valid, 0);
        go = 0; cancel = 0; chk_ack = 0; chk_err = 0;
        @(negedge clk);

        access(48'h0000_1234_5678, 1'b1, 64'h1122_3344_5566_7788, 8'h0F, 0, 1'b0, 0, 0);
        access(48'h0ABC_0000_1F40, 1'b0, '0, '0, 3, 1'b0, 0, 0);
        access(48'h7FFF_FFFF_FFF8, 1'b1, 64'hDEAD_BEEF_0000_0001, 8'hFF, 2, 1'b1, 0, 0);
        access(48'h0000_0000_0010, 1'b0, '0, '0, 0, 1'b1, 0, 0);
        access(48'h0000_2222_3330, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0, 1, 1'b0, 1, 3);
        access(48'h0000_4444_5550, 1'b0, '0, '0, 0, 1'b0, 2, 1);
        access(48'h0000_6666_7778, 1'b1, 64'h0123_4567_89AB_CDEF, 8'h81, 0, 1'b0, 0, 2);
        access(48'h0000_9999_0008, 1'b0, '0, '0, 4, 1'b0, 0, 1);

        repeat (3) @(negedge clk);
        check(exp_mem.size() == 0, "R7", "missing cache accesses", exp_mem.size(), 0);
        check(exp_ld.size() == 0, "R9", "missing load results", exp_ld.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R2 watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule